// File: doc/BRIEF.md
# SECDED Protected Word Memory Controller

This block places a single-port synchronous RAM of 32-bit words behind a plain request/response memory port and guards every stored word with seven check bits: six Hamming bits plus one overall parity bit. Writes encode the check bits on the way in. Reads decode the stored word one cycle after the request. A word with one flipped bit comes back already repaired. A word with two flipped bits comes back with an uncorrectable-error flag beside the response, so the requester can raise a bus fault.

A small register port sits next to the memory port and gives diagnostics:
- a saturating counter of corrected reads;
- a status register with write-one-to-clear error flags;
- latches that hold the address of the first correctable failure and of the first uncorrectable failure;
- an interrupt enable;
- two one-shot fault-injection masks, one for data bits and one for check bits, which corrupt the next stored word on purpose so software can test the repair and detect paths.

Software that sees the interrupt reads the failing address, then reads and rewrites that word to scrub it.

Top module: `secded_mem_ctrl`

## Requirements
- R1: A read request (memReq=1, memWe=0) sampled at a clock edge gives memRvalid=1 in the following cycle, with memRdata equal to the last data written to that address. If no bit is corrupted, memUe=0. memRvalid is 0 in every cycle that does not follow a read request.
- R2: When exactly one bit of the stored word is corrupted, the read returns the originally written data with memUe=0. This holds whether the corrupted bit is a data bit, a Hamming bit or the parity bit.
- R3: When exactly two bits of the stored word are corrupted, the response has memRvalid=1 and memUe=1.
- R4: The correctable counter is read at register offset 2, right-aligned. It goes up by one for each read that has a corrected single-bit error. It holds at its all-ones value of 2^CNT_W-1 (default CNT_W=10, so 1023). Any write to offset 2 sets it to zero.
- R5: The status register is at offset 0. Bit 0 is the correctable flag. The first correctable error sets bit 0 and latches the read address into offset 3. Later correctable errors leave offset 3 unchanged while bit 0 stays set. Writing 1 to bit 0 clears the flag and re-arms the latch.
- R6: Bit 1 of status is the uncorrectable flag. The first uncorrectable error sets bit 1 and latches the read address into offset 4, which holds against later uncorrectable errors. Writing 1 to bit 1 clears the flag.
- R7: Offset 1 bit 0 is the interrupt enable. irq is 1 exactly when status bit 0 and the enable are both 1.
- R8: Offset 5 holds a 32-bit data injection mask and offset 6 holds a 7-bit check-bit injection mask (bits 5:0 are the Hamming bits, bit 6 is parity). Both are XORed into the next memory write only, and both read back as 0 after that write. Writes after that are stored clean.
- R9: Register reads are combinational from regAddr. Offset 7 reads as 0. Status bits 31:2 read as 0.
- R10: After reset, every register reads 0, irq=0 and memRvalid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | 1 | Memory access request |
| memWe | input | 1 | 1 = write, 0 = read |
| memAddr | input | ADDR_W | Word address |
| memWdata | input | 32 | Write data |
| memRvalid | output | 1 | Read response valid |
| memRdata | output | 32 | Corrected read data |
| memUe | output | 1 | Uncorrectable error on this response |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| irq | output | 1 | Correctable-error interrupt |

## Verification
The bench repairs errors at each kind of bit position: a data bit, a Hamming bit, and the lone parity bit. A decoder that used only the syndrome would flag the parity-only case wrongly or miss it. Double flips that span the data and check fields must raise memUe; a decoder that "repairs" them would instead return wrong data silently. The bench drives more than 1023 corrected reads against the counter, where a wrapping counter would drop back to zero. It also repeats failures while a flag is still set, which catches latches that overwrite the first failing address. Finally, it writes again after an injection to show that the mask was used once, since a mask that did not clear would corrupt the clean rewrite.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CHK_W  = HAM_W + 1;
  localparam int POS_MAX = DATA_W + HAM_W;

  localparam logic [2:0] REG_STATUS = 3'd0;
  localparam logic [2:0] REG_CTRL   = 3'd1;
  localparam logic [2:0] REG_CECNT  = 3'd2;
  localparam logic [2:0] REG_CEADDR = 3'd3;
  localparam logic [2:0] REG_UEADDR = 3'd4;
  localparam logic [2:0] REG_INJD   = 3'd5;
  localparam logic [2:0] REG_INJC   = 3'd6;

  // control -> datapath
  typedef struct packed {
    logic [DATA_W-1:0] injData;
    logic [CHK_W-1:0]  injCheck;
  } ctl2dp_t;

  // datapath -> control
  typedef struct packed {
    logic rdDone;
    logic ce;
    logic ue;
  } dp2ctl_t;

  // Hamming bits over data placed at non-power-of-two positions 1..POS_MAX
  function automatic logic [HAM_W-1:0] hamChecks(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 1; pos <= POS_MAX; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int j = 0; j < HAM_W; j++)
          if (((pos >> j) & 1) == 1) c[j] = c[j] ^ d[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] fixData(input logic [DATA_W-1:0] d,
                                                input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] r;
    int k;
    r = d;
    k = 0;
    for (int pos = 1; pos <= POS_MAX; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (syn == 6'(pos)) r[k] = ~d[k];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  input  ctl2dp_t           ctl,
  output logic              memRvalid,
  output logic [DATA_W-1:0] memRdata,
  output logic              memUe,
  output dp2ctl_t           dpSt,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + CHK_W;

  logic [WORD_W-1:0] ram [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic              rdPend;

  logic [HAM_W-1:0]  wrHam;
  logic [CHK_W-1:0]  wrChk;
  logic [DATA_W-1:0] rdData;
  logic [CHK_W-1:0]  rdChk;
  logic [HAM_W-1:0]  syn;
  logic              parErr;
  logic              ceNow;
  logic              ueNow;

  always_comb begin
    wrHam = hamChecks(memWdata);
    wrChk = {^{wrHam, memWdata}, wrHam};
  end

  always_ff @(posedge clk) begin
    if (memReq && memWe)
      ram[memAddr] <= {wrChk ^ ctl.injCheck, memWdata ^ ctl.injData};
    if (memReq && !memWe) begin
      rdWord <= ram[memAddr];
      rdAddr <= memAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdPend <= 1'b0;
    else       rdPend <= memReq && !memWe;
  end

  always_comb begin
    rdData = rdWord[DATA_W-1:0];
    rdChk  = rdWord[WORD_W-1:DATA_W];
    syn    = hamChecks(rdData) ^ rdChk[HAM_W-1:0];
    parErr = ^rdWord;
    ceNow  = parErr && (syn <= 6'(POS_MAX));
    ueNow  = (!parErr && syn != '0) || (parErr && syn > 6'(POS_MAX));
  end

  assign memRvalid   = rdPend;
  assign memRdata    = fixData(rdData, syn);
  assign memUe       = rdPend && ueNow;
  assign dpSt.rdDone = rdPend;
  assign dpSt.ce     = rdPend && ceNow;
  assign dpSt.ue     = rdPend && ueNow;

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> memRvalid); // R1
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && !memWe) |=> !memRvalid); // R1
endmodule

// File: rtl/secded_control.sv
module secded_control
  import secded_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              wrFire,
  input  dp2ctl_t           dpSt,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctl2dp_t           ctl,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              ceFlag, ueFlag, irqEn;
  logic [CNT_W-1:0]  ceCnt;
  logic [ADDR_W-1:0] ceAddr, ueAddr;
  logic [DATA_W-1:0] injD;
  logic [CHK_W-1:0]  injC;
  logic              wStatus, wCtrl, wCnt, wInjD, wInjC;

  assign wStatus = regWe && regAddr == REG_STATUS;
  assign wCtrl   = regWe && regAddr == REG_CTRL;
  assign wCnt    = regWe && regAddr == REG_CECNT;
  assign wInjD   = regWe && regAddr == REG_INJD;
  assign wInjC   = regWe && regAddr == REG_INJC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceFlag <= 1'b0;
      ueFlag <= 1'b0;
      irqEn  <= 1'b0;
      ceCnt  <= '0;
      ceAddr <= '0;
      ueAddr <= '0;
      injD   <= '0;
      injC   <= '0;
    end else begin
      if (dpSt.ce) ceFlag <= 1'b1;
      else if (wStatus && regWdata[0]) ceFlag <= 1'b0;
      if (dpSt.ue) ueFlag <= 1'b1;
      else if (wStatus && regWdata[1]) ueFlag <= 1'b0;
      if (dpSt.ce && !ceFlag) ceAddr <= rdAddr;
      if (dpSt.ue && !ueFlag) ueAddr <= rdAddr;
      if (wCtrl) irqEn <= regWdata[0];
      if (wCnt) ceCnt <= '0;
      else if (dpSt.ce && ceCnt != CNT_MAX) ceCnt <= ceCnt + 1'b1;
      if (wInjD) injD <= regWdata;
      else if (wrFire) injD <= '0;
      if (wInjC) injC <= regWdata[CHK_W-1:0];
      else if (wrFire) injC <= '0;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_STATUS: regRdata = {{(DATA_W-2){1'b0}}, ueFlag, ceFlag};
      REG_CTRL:   regRdata = {{(DATA_W-1){1'b0}}, irqEn};
      REG_CECNT:  regRdata = {{(DATA_W-CNT_W){1'b0}}, ceCnt};
      REG_CEADDR: regRdata = {{(DATA_W-ADDR_W){1'b0}}, ceAddr};
      REG_UEADDR: regRdata = {{(DATA_W-ADDR_W){1'b0}}, ueAddr};
      REG_INJD:   regRdata = injD;
      REG_INJC:   regRdata = {{(DATA_W-CHK_W){1'b0}}, injC};
      default:    regRdata = '0;
    endcase
  end

  assign ctl.injData  = injD;
  assign ctl.injCheck = injC;
  assign irq = ceFlag && irqEn;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !wCnt |=> (ceCnt == $past(ceCnt) || ceCnt == $past(ceCnt) + 1'b1)); // R4
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (ceCnt == CNT_MAX && !wCnt) |=> ceCnt == CNT_MAX); // R4
  AST_CE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ceFlag && !(wStatus && regWdata[0])) |=> $stable(ceAddr)); // R5
  AST_UE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ueFlag && !(wStatus && regWdata[1])) |=> $stable(ueAddr)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(ceFlag || dpSt.ce)); // R7
  AST_INJ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (wrFire && !wInjD && !wInjC) |=> (injD == '0 && injC == '0)); // R8
endmodule

// File: rtl/secded_mem_ctrl.sv
module secded_mem_ctrl
  import secded_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memWdata,
  output logic              memRvalid,
  output logic [31:0]       memRdata,
  output logic              memUe,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  ctl2dp_t           ctl;
  dp2ctl_t           dpSt;
  logic [ADDR_W-1:0] rdAddr;

  secded_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .ctl(ctl),
    .memRvalid(memRvalid), .memRdata(memRdata), .memUe(memUe),
    .dpSt(dpSt), .rdAddr(rdAddr)
  );

  secded_control #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .wrFire(memReq && memWe),
    .dpSt(dpSt), .rdAddr(rdAddr), .ctl(ctl), .irq(irq)
  );
endmodule

// File: tb/sim_secded_mem_ctrl.sv
`timescale 1ns/1ps
module sim_secded_mem_ctrl;
  localparam int AW = 6;
  localparam int CW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq = 1'b0, memWe = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic [31:0] memWdata = '0;
  logic memRvalid, memUe, irq;
  logic [31:0] memRdata, regRdata;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit resetPhase = 1'b1;

  always #5 clk = ~clk;

  secded_mem_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRvalid(memRvalid), .memRdata(memRdata), .memUe(memUe),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] mData [64];
  int          mFlips [64];
  logic [31:0] mInjD;
  logic [6:0]  mInjC;
  bit mIrqEn, mCeFlag, mUeFlag;
  int mCnt, mCeAddr, mUeAddr;
  bit pValid; int pAddr; int pFlips; logic [31:0] pData;

  always @(posedge clk) begin
    if (!rstN) begin
      mInjD = '0; mInjC = '0; mIrqEn = 0; mCeFlag = 0; mUeFlag = 0;
      mCnt = 0; mCeAddr = 0; mUeAddr = 0; pValid = 0;
    end else begin
      bit ceEv, ueEv;
      ceEv = pValid && pFlips == 1;
      ueEv = pValid && pFlips == 2;
      if (regWe && regAddr == 3'd0) begin
        if (regWdata[0]) mCeFlag = 0;
        if (regWdata[1]) mUeFlag = 0;
      end
      if (ceEv) begin
        if (!mCeFlag) mCeAddr = pAddr;
        mCeFlag = 1;
        if (mCnt < CMAX) mCnt++;
      end
      if (ueEv) begin
        if (!mUeFlag) mUeAddr = pAddr;
        mUeFlag = 1;
      end
      if (regWe && regAddr == 3'd2) mCnt = 0;
      if (regWe && regAddr == 3'd1) mIrqEn = regWdata[0];
      pValid = memReq && !memWe;
      if (pValid) begin
        pAddr = int'(memAddr); pFlips = mFlips[memAddr]; pData = mData[memAddr];
      end
      if (memReq && memWe) begin
        mData[memAddr] = memWdata;
        mFlips[memAddr] = $countones(mInjD) + $countones(mInjC);
        mInjD = '0; mInjC = '0;
      end
      if (regWe && regAddr == 3'd5) mInjD = regWdata;
      if (regWe && regAddr == 3'd6) mInjC = regWdata[6:0];
    end
  end

  function automatic logic [31:0] expReg(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, mUeFlag, mCeFlag};
      3'd1: return {31'd0, mIrqEn};
      3'd2: return 32'(mCnt);
      3'd3: return 32'(mCeAddr);
      3'd4: return 32'(mUeAddr);
      3'd5: return mInjD;
      3'd6: return {25'd0, mInjC};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string regTag(input logic [2:0] a);
    case (a)
      3'd0: return "R5/R6";
      3'd1: return "R7";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5, 3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string t;
    cycles++;
    t = resetPhase ? "R10" : "R1";
    check(t, "memRvalid", {31'd0, memRvalid}, {31'd0, pValid && rstN});
    check(resetPhase ? "R10" : "R7", "irq", {31'd0, irq}, {31'd0, mCeFlag && mIrqEn});
    check(resetPhase ? "R10" : regTag(regAddr), "regRdata", regRdata, expReg(regAddr));
    if (pValid && rstN) begin
      check(pFlips == 2 ? "R3" : "R1", "memUe", {31'd0, memUe}, {31'd0, pFlips == 2});
      if (pFlips < 2)
        check(pFlips == 1 ? "R2" : "R1", "memRdata", memRdata, pData);
    end
  end

  task automatic step;
    @(posedge clk); #1;
    memReq = 0; memWe = 0; regWe = 0;
  endtask
  task automatic wr(input int a, input logic [31:0] d);
    memReq = 1; memWe = 1; memAddr = AW'(a); memWdata = d; step();
  endtask
  task automatic rd(input int a);
    memReq = 1; memWe = 0; memAddr = AW'(a); step();
  endtask
  task automatic regW(input logic [2:0] a, input logic [31:0] d);
    regWe = 1; regAddr = a; regWdata = d; step();
  endtask
  task automatic look(input logic [2:0] a);
    regAddr = a; step();
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R10: reset values of every register
    for (int a = 0; a < 8; a++) look(3'(a));
    resetPhase = 0;
    // R1: clean traffic
    wr(0, 32'h0000_0000); wr(1, 32'hFFFF_FFFF); wr(2, 32'hA5A5_5A5A);
    rd(0); rd(1); rd(2); rd(2);
    // R2/R8: single data-bit flip at addr 3
    regW(3'd5, 32'h0000_0080); look(3'd5);
    wr(3, 32'h1234_5678); look(3'd5);
    rd(3); look(3'd0); look(3'd3); look(3'd2);
    // R2: single Hamming-bit flip at addr 9; R5 address holds
    regW(3'd6, 32'h0000_0004); wr(9, 32'hCAFE_F00D); rd(9); look(3'd3); look(3'd2);
    // R2: parity-bit only flip at addr 10
    regW(3'd6, 32'h0000_0040); wr(10, 32'h0F0F_0F0F); rd(10); look(3'd2);
    // R7: interrupt enable
    regW(3'd1, 32'h1); look(3'd1);
    // R5: W1C then relatch
    regW(3'd0, 32'h1); look(3'd0);
    rd(9); look(3'd3); look(3'd0);
    regW(3'd1, 32'h0); look(3'd0);
    // R3/R6: double flips
    regW(3'd5, 32'h0000_0003); wr(20, 32'hDEAD_BEEF); rd(20); look(3'd4); look(3'd0);
    regW(3'd5, 32'h8000_0000); regW(3'd6, 32'h0000_0001); wr(21, 32'h5555_AAAA);
    rd(21); look(3'd4);
    regW(3'd0, 32'h2); look(3'd0); rd(21); look(3'd4);
    // R8: masks used once; rewrite is clean
    look(3'd5); look(3'd6); wr(3, 32'h1234_5678); rd(3); look(3'd2);
    // R4: clear then saturate
    regW(3'd2, 32'h0); look(3'd2);
    regW(3'd5, 32'h0001_0000); wr(40, 32'h7777_1111);
    for (int i = 0; i < CMAX + 8; i++) rd(40);
    look(3'd2); regW(3'd2, 32'h0); look(3'd2);
    // R9: unused offset
    look(3'd7);
    // R1: varied patterns
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(44 + i, lfsr);
    end
    for (int i = 0; i < 20; i++) rd(44 + i);
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule